// File: doc/BRIEF.md
# Bidirectional Latched Byte Transceiver

This block moves a data word between two ports, A and B, in either direction without changing any bit. Each direction has its own storage latch and three active-low controls: a direction enable, a capture control and a drive control. In the A-to-B direction, the latch takes its value from the A input and presents it on the B output. The B-to-A direction is the mirror image: it captures from the B input and presents on the A output. Because each direction has its own latch, the block can hold one word going each way at the same time.

Each port has three signals in place of a true bidirectional pin: an input word, an output word and a drive flag. The surrounding logic builds a tri-state bus from them and drives high impedance while the drive flag is low. While a latch is open, its output follows its input within the same evaluation step; there is no clock edge in the path. An active-low asynchronous reset clears both latches. A contention flag reports the case where both ports drive at the same time.

Top module: `xcvr_top`

## Requirements
- R1: Data passes without inversion. While the A-to-B latch is open, `b_out` equals `a_in` in every bit. While the B-to-A latch is open, `a_out` equals `b_in` in every bit.
- R2: The A-to-B latch is open only while `ab_en_n` = 0 and `ab_le_n` = 0. At any other time, a change on `a_in` leaves `b_out` unchanged.
- R3: When `ab_le_n` goes from 0 to 1 with `ab_en_n` = 0, the latch keeps the word it held at that moment and stops following `a_in`.
- R4: While `ab_en_n` = 1, the A-to-B latch keeps its contents whatever `ab_le_n` and `a_in` do, and `b_oe` = 0.
- R5: `b_oe` = 1 exactly when `ab_en_n` = 0 and `ab_oe_n` = 0. `b_out` always shows the A-to-B latch contents, whatever the value of `b_oe`.
- R6: The B-to-A direction behaves the same way. It uses `ba_en_n`, `ba_le_n` and `ba_oe_n`, captures from `b_in`, and drives `a_out` and `a_oe`. The controls of one direction have no effect on the other direction.
- R7: While `rst_n` = 0, both latches are cleared to zero at once, with no clock, so `a_out` = 0 and `b_out` = 0.
- R8: `contention` = 1 exactly when `a_oe` and `b_oe` are both 1. The flag changes nothing else.
- R9: Both latches can hold different words at the same time, and each direction keeps its word while the other direction captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous clear of both latches, active low |
| a_in | input | 8 | Word received on port A |
| a_out | output | 8 | B-to-A latch contents presented on port A |
| a_oe | output | 1 | Port A drive flag |
| b_in | input | 8 | Word received on port B |
| b_out | output | 8 | A-to-B latch contents presented on port B |
| b_oe | output | 1 | Port B drive flag |
| ab_en_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B capture control, active low (latch open while low) |
| ab_oe_n | input | 1 | A-to-B drive control, active low |
| ba_en_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A capture control, active low (latch open while low) |
| ba_oe_n | input | 1 | B-to-A drive control, active low |
| contention | output | 1 | Both ports driving at once |

## Verification
The assertions check settled values only. They assume a latch never closes in the same instant that its data input changes, because a real part would need setup and hold time there and the model defines no result for that case. The random stimulus respects this: on each step it changes either the control lines or the data words, never both. Every change is given time to settle before anything is compared. The directed cases open and close each latch while its data is held stable.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

    // Active-low control group for one direction of transfer
    typedef struct packed {
        logic en_n;   // direction enable
        logic le_n;   // capture control, latch open while low
        logic oe_n;   // drive control
    } dir_ctl_t;

    // Decoded state of one direction
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,  // direction disabled: hold, no drive
        MODE_HOLD = 2'd1,  // enabled, latch closed
        MODE_PASS = 2'd2   // enabled, latch transparent
    } lane_mode_t;

    function automatic lane_mode_t decode_mode(input dir_ctl_t c);
        if (c.en_n)      return MODE_OFF;
        else if (c.le_n) return MODE_HOLD;
        else             return MODE_PASS;
    endfunction

endpackage

// File: rtl/xcvr_dir.sv
`timescale 1ns/1ps
module xcvr_dir
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] src,
    output logic [W-1:0] held,
    output logic         drive
);

    typedef struct packed {
        logic         open;
        logic [W-1:0] word;
    } lane_next_t;

    lane_mode_t   mode;
    lane_next_t   lane_d;
    logic [W-1:0] word_q;

    // Next-value computation
    always_comb begin
        mode        = decode_mode(ctl);
        lane_d.open = (mode == MODE_PASS);
        lane_d.word = src;
    end

    // Level-sensitive storage with asynchronous clear
    always_latch begin
        if (!rst_n)
            word_q = '0;
        else if (lane_d.open)
            word_q = lane_d.word;
    end

    assign held  = word_q;
    assign drive = (mode != MODE_OFF) && !ctl.oe_n;

endmodule

// File: rtl/xcvr_clash.sv
`timescale 1ns/1ps
module xcvr_clash #(
    parameter int N = 2
) (
    input  logic [N-1:0] drv,
    output logic         clash
);
    assign clash = &drv;
endmodule

// File: rtl/xcvr_top.sv
`timescale 1ns/1ps
module xcvr_top
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         ab_en_n,
    input  logic         ab_le_n,
    input  logic         ab_oe_n,
    input  logic         ba_en_n,
    input  logic         ba_le_n,
    input  logic         ba_oe_n,
    output logic         contention
);

    localparam int NDIR = 2;   // index 0: A-to-B, index 1: B-to-A

    dir_ctl_t     ctl_v  [NDIR];
    logic [W-1:0] src_v  [NDIR];
    logic [W-1:0] held_v [NDIR];
    logic [NDIR-1:0] drv_v;

    assign ctl_v[0] = '{en_n: ab_en_n, le_n: ab_le_n, oe_n: ab_oe_n};
    assign ctl_v[1] = '{en_n: ba_en_n, le_n: ba_le_n, oe_n: ba_oe_n};
    assign src_v[0] = a_in;
    assign src_v[1] = b_in;

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        xcvr_dir #(.W(W)) u_dir (
            .rst_n (rst_n),
            .ctl   (ctl_v[g]),
            .src   (src_v[g]),
            .held  (held_v[g]),
            .drive (drv_v[g])
        );
    end

    assign b_out = held_v[0];
    assign b_oe  = drv_v[0];
    assign a_out = held_v[1];
    assign a_oe  = drv_v[1];

    xcvr_clash #(.N(NDIR)) u_clash (
        .drv   (drv_v),
        .clash (contention)
    );

endmodule

// File: rtl/xcvr_chk.sv
`timescale 1ns/1ps
module xcvr_chk #(
    parameter int W = 8
) (
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         ab_en_n,
    input logic         ab_le_n,
    input logic         ab_oe_n,
    input logic         ba_en_n,
    input logic         ba_le_n,
    input logic         ba_oe_n,
    input logic         contention
);

    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEARS: assert (a_out == '0 && b_out == '0) else $error("reset clear"); // R7
        end else begin
            AST_AB_FOLLOWS: assert (ab_en_n || ab_le_n || b_out == a_in) else $error("ab pass"); // R1
            AST_BA_FOLLOWS: assert (ba_en_n || ba_le_n || a_out == b_in) else $error("ba pass"); // R6
            AST_AB_QUIET_OFF: assert (!ab_en_n || !b_oe) else $error("ab off"); // R4
            AST_AB_DRIVE: assert (b_oe == (!ab_en_n && !ab_oe_n)) else $error("ab drive"); // R5
            AST_BA_DRIVE: assert (a_oe == (!ba_en_n && !ba_oe_n)) else $error("ba drive"); // R6
            AST_CLASH_FLAG: assert (contention == (a_oe && b_oe)) else $error("clash"); // R8
        end
    end

endmodule

bind xcvr_top xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/tb_xcvr_top.sv
`timescale 1ns/1ps
module tb_xcvr_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic       rst_n;
    logic [7:0] a_in, b_in, a_out, b_out;
    logic       a_oe, b_oe, contention;
    logic       ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [7:0] exp_ab, exp_ba;   // bench model of the two latches

    xcvr_top dut (.*);

    function automatic logic drives(input logic en_n, input logic oe_n);
        return !en_n && !oe_n;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_update();
        if (!rst_n) begin
            exp_ab = '0;
            exp_ba = '0;
        end else begin
            if (!ab_en_n && !ab_le_n) exp_ab = a_in;
            if (!ba_en_n && !ba_le_n) exp_ba = b_in;
        end
    endtask

    // Settle, update the model, compare every output
    task automatic settle(input string rd);
        #2;
        model_update();
        chk({rd, " b_out"}, b_out, exp_ab);
        chk("R6 a_out", a_out, exp_ba);
        chk("R5 b_oe", b_oe, drives(ab_en_n, ab_oe_n));
        chk("R6 a_oe", a_oe, drives(ba_en_n, ba_oe_n));
        chk("R8 contention", contention,
            drives(ab_en_n, ab_oe_n) && drives(ba_en_n, ba_oe_n));
    endtask

    initial begin
        rst_n = 0; a_in = 0; b_in = 0;
        ab_en_n = 1; ab_le_n = 1; ab_oe_n = 1;
        ba_en_n = 1; ba_le_n = 1; ba_oe_n = 1;
        exp_ab = 0; exp_ba = 0;
        @(negedge clk);
        a_in = 8'hEE; b_in = 8'hDD; ab_en_n = 0; ab_le_n = 0; ba_en_n = 0; ba_le_n = 0;
        #2;
        chk("R7 reset b_out", b_out, 8'h00);
        chk("R7 reset a_out", a_out, 8'h00);
        ab_en_n = 1; ab_le_n = 1; ba_en_n = 1; ba_le_n = 1;
        @(negedge clk); rst_n = 1; settle("R7");

        // R1: transparent pass, no inversion
        @(negedge clk); ab_en_n = 0; ab_oe_n = 0; settle("R5");
        @(negedge clk); a_in = 8'h5A; settle("R1");
        @(negedge clk); ab_le_n = 0; settle("R1");
        chk("R1 pass 5A", b_out, 8'h5A);
        @(negedge clk); a_in = 8'hA5; settle("R1");
        chk("R1 follow A5", b_out, 8'hA5);
        // R3: close latch, then change data
        @(negedge clk); ab_le_n = 1; settle("R3");
        @(negedge clk); a_in = 8'h3C; settle("R2");
        chk("R3 held A5", b_out, 8'hA5);
        // R4: direction disabled, latch control ignored
        @(negedge clk); ab_en_n = 1; settle("R4");
        chk("R4 b_oe off", b_oe, 1'b0);
        @(negedge clk); ab_le_n = 0; settle("R4");
        @(negedge clk); a_in = 8'hFF; settle("R4");
        chk("R4 held through le", b_out, 8'hA5);
        @(negedge clk); ab_le_n = 1; settle("R4");
        @(negedge clk); ab_en_n = 0; settle("R4");
        chk("R4 still A5", b_out, 8'hA5);
        // R5: drive control high gives no drive, data still shown
        @(negedge clk); ab_oe_n = 1; settle("R5");
        chk("R5 no drive", b_oe, 1'b0);
        chk("R5 data visible", b_out, 8'hA5);
        // R6/R9: B-to-A capture while A-to-B holds
        @(negedge clk); b_in = 8'hC3; ba_en_n = 0; ba_le_n = 0; ba_oe_n = 0; settle("R9");
        chk("R6 a_out C3", a_out, 8'hC3);
        @(negedge clk); ba_le_n = 1; settle("R9");
        @(negedge clk); b_in = 8'h11; a_in = 8'h22; settle("R9");
        chk("R9 ab word", b_out, 8'hA5);
        chk("R9 ba word", a_out, 8'hC3);
        // R8: both drive
        @(negedge clk); ab_oe_n = 0; settle("R8");
        chk("R8 clash on", contention, 1'b1);
        @(negedge clk); ba_oe_n = 1; settle("R8");
        chk("R8 clash off", contention, 1'b0);
        // R7: asynchronous clear mid-run
        #3; rst_n = 0; #1;
        chk("R7 async b", b_out, 8'h00);
        chk("R7 async a", a_out, 8'h00);
        @(negedge clk); settle("R7");
        @(negedge clk); rst_n = 1; settle("R7");

        // Random phase: controls and data never change together
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (i % 2 == 0) begin
                {ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n} = 6'($urandom);
            end else begin
                a_in = 8'($urandom);
                b_in = 8'($urandom);
            end
            settle("R1");
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule